// File: doc/BRIEF.md
# Load Queue with Recycled Tag Pool

This block keeps the loads that a core has dispatched but not yet retired, oldest first, and gives each of them a short queue tag that other pipeline logic uses to name the load. Tags are not slot positions. They come from a pool holding twice as many tags as the queue has entries. A freed tag is only reissued after the rest of the pool has been offered, so a stale reference to a retired load is unlikely to alias a new one soon after.

Dispatch offers one load per cycle with its sequence number and gets the tag back in the same cycle. A commit broadcast retires every leading entry whose sequence number is at or below the committed number. A squash broadcast drops every trailing entry younger than the squash number. The block also reports a free-entry figure for dispatch that merges its own free space with the store queue's. It holds two pieces of replay status: a stalled load, named by its tag, and a blocked load, named by its sequence number. A squash clears each of these when it removes the load it refers to.

Top module: `lq_tag_queue`

## Requirements
- R1: After reset the queue is empty (`lqCount` 0, `headValid` 0), every one of the 2·DEPTH tags is free, the first tag offered is 0, and both `stalled` and `loadBlocked` are low.
- R2: An allocation is accepted (`allocOk` high, in the same cycle as `allocValid`) when the queue holds fewer than DEPTH loads, the pool is not empty and no squash is present in that cycle. The load becomes the youngest entry and `lqCount` rises by one at the next edge.
- R3: An allocation that cannot be accepted raises `allocReject` in the same cycle and changes neither the queue nor the pool.
- R4: With `commitValid`, all leading entries whose sequence number is less than or equal to `commitSeq` (unsigned compare) leave the queue at the next edge, and their tags return to the pool.
- R5: With `squashValid`, all trailing entries whose sequence number is greater than `squashSeq` leave the queue at the next edge and their tags return to the pool. An entry that commit retires in the same cycle is not counted twice.
- R6: `headValid` is high whenever the queue is not empty, and `headTag` then shows the tag of the oldest entry.
- R7: `freeEntries` is min(DEPTH − `lqCount`, `sqFree`) − 1, held at 0 when that minimum is 0. It is combinational from its inputs.
- R8: `stallSet` records `stallSetTag` and raises `stalled`. `stallRelease` clears it. A squash that removes the entry carrying the recorded tag clears it too, and this takes priority over a set in the same cycle.
- R9: `blockSet` records `blockSetSeq`, raises `loadBlocked` and clears `blockHandled`. `blockAck` raises `blockHandled` while blocked. A squash with `squashSeq` below the recorded number clears all three, and this takes priority.
- R10: The offered tag is the first free tag found by searching upward, with wrap, from the tag after the last one issued. A tag released at an edge can be offered from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Request to enter a load |
| allocSeq | input | SEQ_W | Sequence number of the load |
| allocTag | output | TAG_W | Tag offered to the request |
| allocOk | output | 1 | Request accepted this cycle |
| allocReject | output | 1 | Request refused this cycle |
| commitValid | input | 1 | Commit broadcast present |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Squash broadcast present |
| squashSeq | input | SEQ_W | Loads younger than this are removed |
| sqFree | input | CNT_W | Free entries in the store queue |
| freeEntries | output | CNT_W | Free-entry figure for dispatch |
| lqCount | output | CNT_W | Loads held |
| headValid | output | 1 | Queue not empty |
| headTag | output | TAG_W | Tag of the oldest load |
| stallSet | input | 1 | Record a stalled load |
| stallSetTag | input | TAG_W | Tag of the stalled load |
| stallRelease | input | 1 | Clear the stall |
| stalled | output | 1 | A stalled load is recorded |
| stallTag | output | TAG_W | Recorded stalled tag |
| blockSet | input | 1 | Record a blocked load |
| blockSetSeq | input | SEQ_W | Sequence number of the blocked load |
| blockAck | input | 1 | Mark the blocked load as handled |
| loadBlocked | output | 1 | A blocked load is recorded |
| blockHandled | output | 1 | Blocked load has been handled |
| blockSeq | output | SEQ_W | Recorded blocked sequence number |

## Verification
The acceptance decision, the offered tag and the free-entry figure depend on the current state and the inputs of the same cycle, so they are due with no clock delay. The bench samples them a short time after it drives a request, before the next rising edge. Queue occupancy, the head tag and both status records change at the rising edge after the broadcast, so each is compared on the following low phase against a reference model that advances by exactly one step per edge. A released tag is only expected to reappear in the cycle after its release, which tests that the pool never recycles a tag in the cycle that frees it.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic doAlloc;
    logic doRetire;
    logic doSquash;
  } lqStrobe_t;
endpackage

// File: rtl/lq_tag_pool.sv
module lq_tag_pool #(
  parameter int TAGS  = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             take,
  input  logic [TAGS-1:0]  releaseMask,
  output logic [TAG_W-1:0] freeTag,
  output logic             poolEmpty
);
  logic [TAGS-1:0]  freeMap;
  logic [TAG_W-1:0] scanPtr;
  logic             found;

  // rotating search from scanPtr; TAGS is a power of two so wrap is free
  always_comb begin
    found   = 1'b0;
    freeTag = '0;
    for (int i = 0; i < TAGS; i++) begin
      if (!found && freeMap[scanPtr + TAG_W'(i)]) begin
        found   = 1'b1;
        freeTag = scanPtr + TAG_W'(i);
      end
    end
  end

  assign poolEmpty = !found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeMap <= '1;
      scanPtr <= '0;
    end else begin
      if (take) begin
        freeMap <= (freeMap | releaseMask) & ~(TAGS'(1) << freeTag);
        scanPtr <= freeTag + TAG_W'(1);
      end else begin
        freeMap <= freeMap | releaseMask;
      end
    end
  end
endmodule

// File: rtl/lq_datapath.sv
module lq_datapath import lq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int TAGS  = 16,
  parameter int TAG_W = 4,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  lqStrobe_t        strobe,
  input  logic [CNT_W-1:0] retireCnt,
  input  logic [CNT_W-1:0] squashCnt,
  input  logic [CNT_W-1:0] count,
  input  logic [SEQ_W-1:0] allocSeq,
  input  logic [TAG_W-1:0] allocTag,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [TAG_W-1:0] stallTag,
  output logic [DEPTH-1:0] retHit,
  output logic [DEPTH-1:0] sqHit,
  output logic [DEPTH-1:0] stallHit,
  output logic [TAGS-1:0]  releaseMask,
  output logic [TAG_W-1:0] headTag
);
  logic [SEQ_W-1:0] seqMem [DEPTH];
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [PTR_W-1:0] head;
  logic [PTR_W-1:0] slotOf [DEPTH];
  logic [PTR_W-1:0] tailSlot;

  // per-age compare lanes, index 0 is the oldest entry
  for (genvar g = 0; g < DEPTH; g++) begin : gLane
    assign slotOf[g]   = head + PTR_W'(g);
    assign retHit[g]   = seqMem[slotOf[g]] <= commitSeq;
    assign sqHit[g]    = seqMem[slotOf[g]] >  squashSeq;
    assign stallHit[g] = tagMem[slotOf[g]] == stallTag;
  end

  assign tailSlot = head + count[PTR_W-1:0];
  assign headTag  = tagMem[head];

  always_comb begin
    releaseMask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((strobe.doRetire && i < int'(retireCnt)) ||
          (strobe.doSquash && i >= int'(count) - int'(squashCnt) && i < int'(count)))
        releaseMask[tagMem[slotOf[i]]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doAlloc) begin
      seqMem[tailSlot] <= allocSeq;
      tagMem[tailSlot] <= allocTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               head <= '0;
    else if (strobe.doRetire) head <= head + retireCnt[PTR_W-1:0];
  end
endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl import lq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int TAG_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             commitValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [CNT_W-1:0] sqFree,
  input  logic             poolEmpty,
  input  logic [DEPTH-1:0] retHit,
  input  logic [DEPTH-1:0] sqHit,
  input  logic [DEPTH-1:0] stallHit,
  input  logic             stallSet,
  input  logic [TAG_W-1:0] stallSetTag,
  input  logic             stallRelease,
  input  logic             blockSet,
  input  logic [SEQ_W-1:0] blockSetSeq,
  input  logic             blockAck,
  output lqStrobe_t        strobe,
  output logic [CNT_W-1:0] retireCnt,
  output logic [CNT_W-1:0] squashCnt,
  output logic [CNT_W-1:0] count,
  output logic             allocOk,
  output logic             allocReject,
  output logic [CNT_W-1:0] freeEntries,
  output logic             headValid,
  output logic             stalled,
  output logic [TAG_W-1:0] stallTag,
  output logic             loadBlocked,
  output logic             blockHandled,
  output logic [SEQ_W-1:0] blockSeq
);
  logic             stallKill;
  logic             blockKill;
  logic [CNT_W-1:0] lqFree;
  logic [CNT_W-1:0] minFree;

  // leading run of retirable entries, then trailing run of squashable ones
  always_comb begin
    int  retN;
    int  sqN;
    logic runA;
    logic runB;
    retN = 0;
    sqN  = 0;
    runA = commitValid;
    runB = squashValid;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(count) && runA && retHit[i]) retN++;
      else                                        runA = 1'b0;
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < int'(count) && i >= retN) begin
        if (runB && sqHit[i]) sqN++;
        else                  runB = 1'b0;
      end
    end
    stallKill = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= int'(count) - sqN && i < int'(count) && stallHit[i])
        stallKill = stalled;
    end
    retireCnt = CNT_W'(retN);
    squashCnt = CNT_W'(sqN);
  end

  assign allocOk     = allocValid && !squashValid && !poolEmpty && (count < CNT_W'(DEPTH));
  assign allocReject = allocValid && !allocOk;
  assign headValid   = count != '0;
  assign blockKill   = squashValid && loadBlocked && (squashSeq < blockSeq);

  assign strobe.doAlloc  = allocOk;
  assign strobe.doRetire = retireCnt != '0;
  assign strobe.doSquash = squashCnt != '0;

  assign lqFree      = CNT_W'(DEPTH) - count;
  assign minFree     = (lqFree < sqFree) ? lqFree : sqFree;
  assign freeEntries = (minFree == '0) ? '0 : minFree - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      stalled      <= 1'b0;
      stallTag     <= '0;
      loadBlocked  <= 1'b0;
      blockHandled <= 1'b0;
      blockSeq     <= '0;
    end else begin
      count <= count - retireCnt - squashCnt + CNT_W'(allocOk);

      if (stallKill)         stalled <= 1'b0;
      else if (stallSet)     begin stalled <= 1'b1; stallTag <= stallSetTag; end
      else if (stallRelease) stalled <= 1'b0;

      if (blockKill) begin
        loadBlocked  <= 1'b0;
        blockHandled <= 1'b0;
        blockSeq     <= '0;
      end else if (blockSet) begin
        loadBlocked  <= 1'b1;
        blockHandled <= 1'b0;
        blockSeq     <= blockSetSeq;
      end else if (blockAck && loadBlocked) begin
        blockHandled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lq_tag_queue.sv
module lq_tag_queue import lq_pkg::*; #(
  parameter  int DEPTH = 8,
  parameter  int SEQ_W = 16,
  localparam int TAGS  = 2 * DEPTH,
  localparam int TAG_W = $clog2(TAGS),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [SEQ_W-1:0] allocSeq,
  output logic [TAG_W-1:0] allocTag,
  output logic             allocOk,
  output logic             allocReject,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [CNT_W-1:0] sqFree,
  output logic [CNT_W-1:0] freeEntries,
  output logic [CNT_W-1:0] lqCount,
  output logic             headValid,
  output logic [TAG_W-1:0] headTag,
  input  logic             stallSet,
  input  logic [TAG_W-1:0] stallSetTag,
  input  logic             stallRelease,
  output logic             stalled,
  output logic [TAG_W-1:0] stallTag,
  input  logic             blockSet,
  input  logic [SEQ_W-1:0] blockSetSeq,
  input  logic             blockAck,
  output logic             loadBlocked,
  output logic             blockHandled,
  output logic [SEQ_W-1:0] blockSeq
);
  lqStrobe_t        strobe;
  logic [CNT_W-1:0] retireCnt;
  logic [CNT_W-1:0] squashCnt;
  logic [DEPTH-1:0] retHit;
  logic [DEPTH-1:0] sqHit;
  logic [DEPTH-1:0] stallHit;
  logic [TAGS-1:0]  releaseMask;
  logic             poolEmpty;

  lq_tag_pool #(.TAGS(TAGS), .TAG_W(TAG_W)) uPool (
    .clk(clk), .rstN(rstN), .take(allocOk), .releaseMask(releaseMask),
    .freeTag(allocTag), .poolEmpty(poolEmpty)
  );

  lq_datapath #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TAGS(TAGS), .TAG_W(TAG_W),
                .PTR_W(PTR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retireCnt(retireCnt),
    .squashCnt(squashCnt), .count(lqCount), .allocSeq(allocSeq),
    .allocTag(allocTag), .commitSeq(commitSeq), .squashSeq(squashSeq),
    .stallTag(stallTag), .retHit(retHit), .sqHit(sqHit), .stallHit(stallHit),
    .releaseMask(releaseMask), .headTag(headTag)
  );

  lq_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .commitValid(commitValid),
    .squashValid(squashValid), .squashSeq(squashSeq), .sqFree(sqFree),
    .poolEmpty(poolEmpty), .retHit(retHit), .sqHit(sqHit), .stallHit(stallHit),
    .stallSet(stallSet), .stallSetTag(stallSetTag), .stallRelease(stallRelease),
    .blockSet(blockSet), .blockSetSeq(blockSetSeq), .blockAck(blockAck),
    .strobe(strobe), .retireCnt(retireCnt), .squashCnt(squashCnt),
    .count(lqCount), .allocOk(allocOk), .allocReject(allocReject),
    .freeEntries(freeEntries), .headValid(headValid), .stalled(stalled),
    .stallTag(stallTag), .loadBlocked(loadBlocked), .blockHandled(blockHandled),
    .blockSeq(blockSeq)
  );
endmodule

// File: rtl/lq_tag_queue_chk.sv
module lq_tag_queue_chk #(
  parameter  int DEPTH = 8,
  parameter  int SEQ_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocOk,
  input logic             allocReject,
  input logic             commitValid,
  input logic             squashValid,
  input logic [SEQ_W-1:0] squashSeq,
  input logic [CNT_W-1:0] sqFree,
  input logic [CNT_W-1:0] freeEntries,
  input logic [CNT_W-1:0] lqCount,
  input logic             loadBlocked,
  input logic             blockHandled,
  input logic [SEQ_W-1:0] blockSeq
);
  // R3
  full_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && lqCount == CNT_W'(DEPTH)) |-> (allocReject && !allocOk));

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocOk && !commitValid) |=> (lqCount == $past(lqCount) + CNT_W'(1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!allocOk && !commitValid && !squashValid) |=> $stable(lqCount));

  // R4
  commit_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !allocOk) |=> (lqCount <= $past(lqCount)));

  // R7
  free_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sqFree != '0 && lqCount < CNT_W'(DEPTH)) |->
      (freeEntries < sqFree && freeEntries < CNT_W'(DEPTH) - lqCount));

  // R9
  block_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && loadBlocked && squashSeq < blockSeq) |=> (!loadBlocked && !blockHandled));
endmodule

bind lq_tag_queue lq_tag_queue_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uChk (.*);

// File: tb/tb_lq_tag_queue.sv
module tb_lq_tag_queue;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int TAGS  = 16;
  localparam int TAG_W = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic allocValid, commitValid, squashValid, stallSet, stallRelease, blockSet, blockAck;
  logic [SEQ_W-1:0] allocSeq, commitSeq, squashSeq, blockSetSeq, blockSeq;
  logic [CNT_W-1:0] sqFree, freeEntries, lqCount;
  logic [TAG_W-1:0] allocTag, headTag, stallSetTag, stallTag;
  logic allocOk, allocReject, headValid, stalled, loadBlocked, blockHandled;

  lq_tag_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSeq(allocSeq),
    .allocTag(allocTag), .allocOk(allocOk), .allocReject(allocReject),
    .commitValid(commitValid), .commitSeq(commitSeq), .squashValid(squashValid),
    .squashSeq(squashSeq), .sqFree(sqFree), .freeEntries(freeEntries),
    .lqCount(lqCount), .headValid(headValid), .headTag(headTag),
    .stallSet(stallSet), .stallSetTag(stallSetTag), .stallRelease(stallRelease),
    .stalled(stalled), .stallTag(stallTag), .blockSet(blockSet),
    .blockSetSeq(blockSetSeq), .blockAck(blockAck), .loadBlocked(loadBlocked),
    .blockHandled(blockHandled), .blockSeq(blockSeq)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int mSeq[$];
  int mTag[$];
  bit mFree[TAGS];
  int mPtr;
  bit mStalled;
  int mStallTag;
  bit mBlocked, mHandled;
  int mBlockSeq;

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    allocValid = 0; allocSeq = '0; commitValid = 0; commitSeq = '0;
    squashValid = 0; squashSeq = '0; sqFree = CNT_W'(DEPTH);
    stallSet = 0; stallSetTag = '0; stallRelease = 0;
    blockSet = 0; blockSetSeq = '0; blockAck = 0;
  endtask

  task automatic modelReset();
    mSeq.delete(); mTag.delete();
    for (int i = 0; i < TAGS; i++) mFree[i] = 1;
    mPtr = 0; mStalled = 0; mStallTag = 0;
    mBlocked = 0; mHandled = 0; mBlockSeq = 0;
  endtask

  function automatic int pickTag();
    for (int i = 0; i < TAGS; i++)
      if (mFree[(mPtr + i) % TAGS]) return (mPtr + i) % TAGS;
    return -1;
  endfunction

  // called at a falling edge with inputs already driven
  task automatic tick();
    int cnt, lqF, m, expFree, tag, retN, keep;
    bit ok, kill;
    #2;
    cnt = mSeq.size();
    tag = pickTag();
    ok  = allocValid && !squashValid && cnt < DEPTH && tag >= 0;
    lqF = DEPTH - cnt;
    m   = (lqF < int'(sqFree)) ? lqF : int'(sqFree);
    expFree = (m == 0) ? 0 : m - 1;
    chk("R2", "allocOk", int'(allocOk), int'(ok));
    chk("R3", "allocReject", int'(allocReject), int'(allocValid && !ok));
    if (ok) chk("R10", "allocTag", int'(allocTag), tag);
    chk("R7", "freeEntries", int'(freeEntries), expFree);
    chk("R4", "lqCount", int'(lqCount), cnt);
    chk("R6", "headValid", int'(headValid), int'(cnt != 0));
    if (cnt != 0) chk("R6", "headTag", int'(headTag), mTag[0]);
    chk("R8", "stalled", int'(stalled), int'(mStalled));
    if (mStalled) chk("R8", "stallTag", int'(stallTag), mStallTag);
    chk("R9", "loadBlocked", int'(loadBlocked), int'(mBlocked));
    chk("R9", "blockHandled", int'(blockHandled), int'(mHandled));
    if (mBlocked) chk("R9", "blockSeq", int'(blockSeq), mBlockSeq);

    retN = 0;
    if (commitValid) while (retN < cnt && mSeq[retN] <= int'(commitSeq)) retN++;
    keep = cnt;
    if (squashValid) while (keep > retN && mSeq[keep-1] > int'(squashSeq)) keep--;
    kill = 0;
    for (int j = keep; j < cnt; j++) if (mStalled && mTag[j] == mStallTag) kill = 1;
    if (ok) begin mFree[tag] = 0; mPtr = (tag + 1) % TAGS; end
    for (int j = 0; j < retN; j++) mFree[mTag[j]] = 1;
    for (int j = keep; j < cnt; j++) mFree[mTag[j]] = 1;
    repeat (cnt - keep) begin void'(mSeq.pop_back()); void'(mTag.pop_back()); end
    repeat (retN) begin void'(mSeq.pop_front()); void'(mTag.pop_front()); end
    if (ok) begin mSeq.push_back(int'(allocSeq)); mTag.push_back(tag); end

    if (kill) mStalled = 0;
    else if (stallSet) begin mStalled = 1; mStallTag = int'(stallSetTag); end
    else if (stallRelease) mStalled = 0;
    if (squashValid && mBlocked && int'(squashSeq) < mBlockSeq) begin
      mBlocked = 0; mHandled = 0; mBlockSeq = 0;
    end else if (blockSet) begin
      mBlocked = 1; mHandled = 0; mBlockSeq = int'(blockSetSeq);
    end else if (blockAck && mBlocked) mHandled = 1;

    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    int nextSeq;
    rstN = 0;
    idle();
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    // R1 reset state
    chk("R1", "lqCount", int'(lqCount), 0);
    chk("R1", "headValid", int'(headValid), 0);
    chk("R1", "stalled", int'(stalled), 0);
    chk("R1", "loadBlocked", int'(loadBlocked), 0);
    allocValid = 1;
    #1;
    chk("R1", "first allocTag", int'(allocTag), 0);
    idle();
    @(negedge clk);

    // fill past capacity (R2, R3), varied store-queue space (R7)
    for (int i = 1; i <= 9; i++) begin
      allocValid = 1; allocSeq = SEQ_W'(i * 10); sqFree = CNT_W'(i % 9);
      tick();
    end
    // commit up to 35 retires 10,20,30 (R4)
    commitValid = 1; commitSeq = 35;
    tick();
    // squash above 55 removes 60,70,80 (R5)
    squashValid = 1; squashSeq = 55;
    tick();
    chk("R5", "lqCount after squash", int'(lqCount), 2);

    // stall on tag 4 (seq 50), block at 45, then squash above 40 (R8, R9)
    stallSet = 1; stallSetTag = 4;
    tick();
    blockSet = 1; blockSetSeq = 45;
    tick();
    blockAck = 1;
    tick();
    squashValid = 1; squashSeq = 40; allocValid = 1; allocSeq = 100;
    tick();
    chk("R8", "stall cleared by squash", int'(stalled), 0);
    chk("R9", "block cleared by older squash", int'(loadBlocked), 0);
    chk("R5", "lqCount, alloc refused in squash cycle", int'(lqCount), 1);
    // stall on surviving load, squash removes nothing
    stallSet = 1; stallSetTag = 3;
    tick();
    squashValid = 1; squashSeq = 45;
    tick();
    chk("R8", "stall kept when its load survives", int'(stalled), 1);

    // mixed traffic against the model
    nextSeq = 200;
    for (int c = 0; c < 3000; c++) begin
      allocValid = ($urandom % 3) != 0;
      allocSeq   = SEQ_W'(nextSeq);
      nextSeq   += 1 + ($urandom % 3);
      if (($urandom % 4) == 0) begin
        commitValid = 1; commitSeq = SEQ_W'(nextSeq - int'($urandom % 20));
      end
      if (($urandom % 10) == 0) begin
        squashValid = 1; squashSeq = SEQ_W'(nextSeq - int'($urandom % 12));
      end
      if (($urandom % 8) == 0)  begin stallSet = 1; stallSetTag = TAG_W'($urandom % TAGS); end
      if (($urandom % 16) == 0) stallRelease = 1;
      if (($urandom % 16) == 0) begin blockSet = 1; blockSetSeq = SEQ_W'(nextSeq - int'($urandom % 10)); end
      if (($urandom % 8) == 0)  blockAck = 1;
      sqFree = CNT_W'($urandom % (DEPTH + 1));
      tick();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule